// File: doc/BRIEF.md
# Processor Control Register Bank

This block holds the eight 32-bit control registers of a small RISC processor. They sit in a 32-byte window on a big-endian bus that carries byte, halfword and longword accesses. Each register has its own write rules: some bits are masked, some are protected, and some act as one-shot commands. The bank also produces side-effect pulses toward the interrupt logic around it.

A sub-word write works as a read-modify-write inside the bank. The addressed byte or halfword lane of the current register value is replaced, and the rest of the register is kept. The new value is stored in the same clock cycle, so the bus never waits. Reads are combinational from the register state. The flags register shows the live condition codes from the ALU. The last longword is split in two: a write goes to the divide-control register, and a read returns the divider's remainder input.

Top module: `rctl_regbank`

## Requirements
- R1: After reset, a longword read returns 0x00F03000 for PC (offset 0x10), 0x00002800 for control (0x14), 0xFFFFFFFF for data organisation (0x0C), and 0 for flags (live flags low), matrix control (0x04), matrix pointer (0x08) and high data (0x18). Reset also makes the divide-control output 0 and the running output low.
- R2: A longword write (size code 2) to offset 0x04, 0x0C, 0x10 or 0x18 stores all 32 bits, and a longword read at that offset returns them.
- R3: Byte lanes are big-endian. A byte access (size code 0) at address offset k within a longword (k = address bits 1:0) selects bits 31-8k down to 24-8k. A byte write replaces only that byte. A byte read returns it in bits 7:0, with the upper bits zero.
- R4: A halfword access (size code 1) with address bit 1 clear selects bits 31:16, and with it set selects bits 15:0. A halfword write replaces only that half. A halfword read returns it in bits 15:0.
- R5: A halfword write to an odd address changes no register.
- R6: A longword read of flags (offset 0x00) returns zero in bit 0, carry in bit 1 and negative in bit 2, all taken from the live flag inputs. Bits 13:9 read as zero. The other bits read as stored.
- R7: Every write to the matrix pointer (0x08) clears its two low bits.
- R8: A write to control (0x14) leaves the bits under mask 0xF7C0 unchanged.
- R9: A control write whose merged bit 1 is set gives a host interrupt pulse. The pulse is high for exactly the one cycle after the write edge. Bit 1 is never stored.
- R10: A control write whose merged bit 2 is set gives a one-cycle pulse on local interrupt line 0 in the cycle after the write edge. Bit 2 is never stored.
- R11: The running output equals control bit 0.
- R12: A write to offset 0x1C loads the divide-control output, with lane merging against its previous value. A read of 0x1C returns the remainder input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this window |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address within the window |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 longword |
| bus_wdata | input | 32 | Write data, right-justified |
| bus_rdata | output | 32 | Read data, right-justified |
| flag_z_i | input | 1 | Live zero flag |
| flag_c_i | input | 1 | Live carry flag |
| flag_n_i | input | 1 | Live negative flag |
| remain_i | input | 32 | Divider remainder |
| flags_o | output | 32 | Stored flags register |
| divctl_o | output | 32 | Divide-control register |
| run_o | output | 1 | Running flag |
| host_irq_o | output | 1 | Host interrupt request pulse |
| line0_o | output | 1 | Local interrupt line 0 pulse |

## Verification
Some properties are checked by assertions on every cycle:
- The protected control bits never move, and the command bits are never stored.
- The matrix pointer stays aligned.
- A host-interrupt command always yields its pulse.
- An odd halfword write leaves every register unchanged.
- A flags read always carries the live condition codes with bits 13:9 cleared.

Other behaviour can only be shown by the bench's scenarios:
- That the correct byte or halfword lane is merged.
- That reset values and readback values are right.
- That the remainder and divide-control sides of offset 0x1C stay separate.

// File: rtl/rctl_pkg.sv
// Package: shared encodings and constants for the control register bank.
// Assumes a 32-bit register width and a 32-byte window of eight registers.
package rctl_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned NUM_REGS = 8;
    localparam int unsigned ADDR_W = $clog2(NUM_REGS * (DATA_W / 8));
    localparam int unsigned IDX_W = $clog2(NUM_REGS);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_LONG = 2'd2
    } acc_size_e;

    typedef enum logic [IDX_W-1:0] {
        RI_FLAGS = 3'd0,
        RI_MCTL  = 3'd1,
        RI_MPTR  = 3'd2,
        RI_DORG  = 3'd3,
        RI_PC    = 3'd4,
        RI_CTL   = 3'd5,
        RI_HIGH  = 3'd6,
        RI_DIV   = 3'd7
    } reg_idx_e;

    localparam logic [DATA_W-1:0] CTL_KEEP  = 32'h0000_F7C0;
    localparam logic [DATA_W-1:0] CTL_CMD   = 32'h0000_0006;
    localparam logic [DATA_W-1:0] FLAG_HIDE = 32'h0000_3E00;
    localparam logic [DATA_W-1:0] PTR_ALIGN = 32'h0000_0003;

    localparam logic [DATA_W-1:0] RST_PC   = 32'h00F0_3000;
    localparam logic [DATA_W-1:0] RST_CTL  = 32'h0000_2800;
    localparam logic [DATA_W-1:0] RST_DORG = 32'hFFFF_FFFF;
endpackage

// File: rtl/rctl_lane_merge.sv
// Module: merges bus write data into the addressed big-endian lane of a
// base value. Lane 0 is the most significant byte. Halfword writes to an
// odd address are flagged as not allowed. Purely combinational.
module rctl_lane_merge #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [1:0]        size,
    input  logic [1:0]        ofs,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] base,
    output logic [DATA_W-1:0] merged,
    output logic              ok
);
    localparam int unsigned LANES = DATA_W / 8;

    // Legal access check: odd halfword and unknown size are refused
    always_comb begin
        ok = 1'b1;
        if (size == rctl_pkg::SZ_HALF && ofs[0]) ok = 1'b0;
        if (size == 2'd3)                        ok = 1'b0;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int unsigned LO = 8 * (LANES - 1 - i);
        logic       hit;
        logic [7:0] src;
        // Per-lane select and source byte
        always_comb begin
            hit = 1'b0;
            src = wdata[LO +: 8];
            case (size)
                rctl_pkg::SZ_LONG: begin
                    hit = 1'b1;
                    src = wdata[LO +: 8];
                end
                rctl_pkg::SZ_HALF: begin
                    hit = (i / 2) == int'(ofs[1]);
                    src = (i % 2 == 0) ? wdata[15:8] : wdata[7:0];
                end
                rctl_pkg::SZ_BYTE: begin
                    hit = i == int'(ofs);
                    src = wdata[7:0];
                end
                default: hit = 1'b0;
            endcase
        end
        assign merged[LO +: 8] = hit ? src : base[LO +: 8];
    end
endmodule

// File: rtl/rctl_read_mux.sv
// Module: extracts the addressed big-endian byte or halfword of a register
// view and right-justifies it; longword reads pass through. Combinational.
module rctl_read_mux #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [1:0]        size,
    input  logic [1:0]        ofs,
    input  logic [DATA_W-1:0] full,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned LANES = DATA_W / 8;

    // Lane extraction by access size
    always_comb begin
        rdata = '0;
        case (size)
            rctl_pkg::SZ_BYTE: rdata[7:0]  = full[8 * (LANES - 1 - int'(ofs)) +: 8];
            rctl_pkg::SZ_HALF: rdata[15:0] = ofs[1] ? full[15:0] : full[31:16];
            default:           rdata       = full;
        endcase
    end
endmodule

// File: rtl/rctl_regbank.sv
// Module: eight-register control bank on a big-endian byte/half/long bus.
// Assumes one access per cycle and no wait states. Sub-word writes merge
// into the stored value in the same cycle. Slot 7 stores the divide
// control; reads of that offset show the remainder input instead.
module rctl_regbank
    import rctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [4:0]        bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              flag_z_i,
    input  logic              flag_c_i,
    input  logic              flag_n_i,
    input  logic [31:0]       remain_i,
    output logic [31:0]       flags_o,
    output logic [31:0]       divctl_o,
    output logic              run_o,
    output logic              host_irq_o,
    output logic              line0_o
);
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic [IDX_W-1:0]  idx;
    logic [1:0]        ofs;
    logic [DATA_W-1:0] view;
    logic [DATA_W-1:0] merged;
    logic              lane_ok;
    logic              wen;
    logic              host_q;
    logic              line0_q;
    logic [DATA_W-1:0] ctl_q;
    logic [DATA_W-1:0] mptr_q;

    assign idx = bus_addr[ADDR_W-1:2];
    assign ofs = bus_addr[1:0];

    // Read view of the addressed register, with live flags and remainder
    always_comb begin
        view = regs_q[idx];
        if (idx == RI_FLAGS)
            view = (regs_q[RI_FLAGS] & ~FLAG_HIDE & ~32'h7)
                 | {29'd0, flag_n_i, flag_c_i, flag_z_i};
        else if (idx == RI_DIV)
            view = remain_i;
    end

    rctl_lane_merge #(.DATA_W(DATA_W)) u_merge (
        .size   (bus_size),
        .ofs    (ofs),
        .wdata  (bus_wdata),
        .base   (regs_q[idx]),
        .merged (merged),
        .ok     (lane_ok)
    );

    rctl_read_mux #(.DATA_W(DATA_W)) u_rmux (
        .size  (bus_size),
        .ofs   (ofs),
        .full  (view),
        .rdata (bus_rdata)
    );

    assign wen = bus_sel && bus_wr && lane_ok;

    // Register storage with per-register write rules
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q           <= '0;
            regs_q[RI_DORG]  <= RST_DORG;
            regs_q[RI_PC]    <= RST_PC;
            regs_q[RI_CTL]   <= RST_CTL;
        end else if (wen) begin
            case (idx)
                RI_MPTR: regs_q[idx] <= merged & ~PTR_ALIGN;
                RI_CTL:  regs_q[idx] <= (regs_q[RI_CTL] & CTL_KEEP)
                                      | (merged & ~CTL_KEEP & ~CTL_CMD);
                default: regs_q[idx] <= merged;
            endcase
        end
    end

    // One-cycle command pulses from control bits 1 and 2
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_q  <= 1'b0;
            line0_q <= 1'b0;
        end else begin
            host_q  <= wen && (idx == RI_CTL) && merged[1];
            line0_q <= wen && (idx == RI_CTL) && merged[2];
        end
    end

    assign ctl_q      = regs_q[RI_CTL];
    assign mptr_q     = regs_q[RI_MPTR];
    assign flags_o    = regs_q[RI_FLAGS];
    assign divctl_o   = regs_q[RI_DIV];
    assign run_o      = ctl_q[0];
    assign host_irq_o = host_q;
    assign line0_o    = line0_q;
endmodule

// File: rtl/rctl_regbank_chk.sv
// Module: property checker for the control register bank, bound to the top.
// Observes bus ports and the stored registers.
module rctl_regbank_chk (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [4:0]        bus_addr,
    input logic [1:0]        bus_size,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              flag_z_i,
    input logic              flag_c_i,
    input logic              flag_n_i,
    input logic              host_irq_o,
    input logic [7:0][31:0]  regs_q
);
    // Protected control bits never change after reset
    p_ctl_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q[5] & 32'h0000_F7C0) == ($past(regs_q[5]) & 32'h0000_F7C0));

    // Command bits are never held in the control register
    p_cmd_unstored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q[5][2:1] == 2'b00);

    // Matrix pointer stays longword aligned
    p_ptr_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q[2][1:0] == 2'b00);

    // A longword control write with bit 1 yields the host pulse next cycle
    p_host_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 5'h14 && bus_size == 2'd2 && bus_wdata[1])
        |=> host_irq_o);

    // Odd halfword writes leave every register untouched
    p_odd_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_size == 2'd1 && bus_addr[0]) |=> $stable(regs_q));

    // Flags longword read carries live codes and hides bits 13:9
    p_flag_view_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 5'h00 && bus_size == 2'd2)
        |-> (bus_rdata[13:9] == 5'd0 && bus_rdata[2:0] == {flag_n_i, flag_c_i, flag_z_i}));
endmodule

bind rctl_regbank rctl_regbank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .flag_z_i   (flag_z_i),
    .flag_c_i   (flag_c_i),
    .flag_n_i   (flag_n_i),
    .host_irq_o (host_irq_o),
    .regs_q     (regs_q)
);

// File: tb/rctl_regbank_bench.sv
module rctl_regbank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        flag_z_i = 1'b0;
    logic        flag_c_i = 1'b0;
    logic        flag_n_i = 1'b0;
    logic [31:0] remain_i = 32'hCAFE_F00D;
    logic [31:0] flags_o;
    logic [31:0] divctl_o;
    logic        run_o;
    logic        host_irq_o;
    logic        line0_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rctl_regbank u_rctl_regbank (.*);

    typedef struct packed {
        logic        wr;
        logic [1:0]  wsz;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic [1:0]  rsz;
        logic [4:0]  ra;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd2, 5'h04, 32'h1234_5678, 2'd2, 5'h04, 32'h1234_5678, 4'd2},  // R2
        '{1'b1, 2'd0, 5'h05, 32'h0000_00AB, 2'd2, 5'h04, 32'h12AB_5678, 4'd3},  // R3
        '{1'b1, 2'd0, 5'h07, 32'h0000_00CD, 2'd2, 5'h04, 32'h12AB_56CD, 4'd3},  // R3
        '{1'b1, 2'd1, 5'h06, 32'h0000_BEEF, 2'd2, 5'h04, 32'h12AB_BEEF, 4'd4},  // R4
        '{1'b1, 2'd1, 5'h04, 32'h0000_0000, 2'd2, 5'h04, 32'h0000_BEEF, 4'd4},  // R4
        '{1'b1, 2'd1, 5'h05, 32'h0000_FFFF, 2'd2, 5'h04, 32'h0000_BEEF, 4'd5},  // R5
        '{1'b0, 2'd0, 5'h00, 32'h0000_0000, 2'd0, 5'h06, 32'h0000_00BE, 4'd3},  // R3
        '{1'b0, 2'd0, 5'h00, 32'h0000_0000, 2'd1, 5'h06, 32'h0000_BEEF, 4'd4},  // R4
        '{1'b1, 2'd2, 5'h08, 32'hFFFF_FFFF, 2'd2, 5'h08, 32'hFFFF_FFFC, 4'd7},  // R7
        '{1'b1, 2'd0, 5'h0B, 32'h0000_0007, 2'd2, 5'h08, 32'hFFFF_FF04, 4'd7},  // R7
        '{1'b1, 2'd2, 5'h10, 32'h00F0_3ABC, 2'd2, 5'h10, 32'h00F0_3ABC, 4'd2},  // R2
        '{1'b1, 2'd2, 5'h18, 32'hDEAD_BEEF, 2'd2, 5'h18, 32'hDEAD_BEEF, 4'd2},  // R2
        '{1'b1, 2'd2, 5'h1C, 32'h0000_0055, 2'd2, 5'h1C, 32'hCAFE_F00D, 4'd12}, // R12
        '{1'b1, 2'd2, 5'h0C, 32'h0102_0304, 2'd0, 5'h0C, 32'h0000_0001, 4'd3},  // R3
        '{1'b1, 2'd2, 5'h14, 32'hFFFF_FFFF, 2'd2, 5'h14, 32'hFFFF_2839, 4'd8},  // R8
        '{1'b1, 2'd2, 5'h14, 32'h0000_0000, 2'd2, 5'h14, 32'h0000_2000, 4'd8},  // R8
        '{1'b1, 2'd2, 5'h00, 32'hFFFF_FFFF, 2'd2, 5'h00, 32'hFFFF_C1F8, 4'd6}   // R6
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] sz, input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
    endtask

    task automatic do_read(input logic [1:0] sz, input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_size = sz; bus_addr = a;
        #1;
        v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        do_read(2'd2, 5'h00, v); chk("R1 flags", v, 32'h0);
        do_read(2'd2, 5'h04, v); chk("R1 mctl", v, 32'h0);
        do_read(2'd2, 5'h08, v); chk("R1 mptr", v, 32'h0);
        do_read(2'd2, 5'h0C, v); chk("R1 dorg", v, 32'hFFFF_FFFF);
        do_read(2'd2, 5'h10, v); chk("R1 pc", v, 32'h00F0_3000);
        do_read(2'd2, 5'h14, v); chk("R1 ctl", v, 32'h0000_2800);
        do_read(2'd2, 5'h18, v); chk("R1 high", v, 32'h0);
        chk("R1 divctl", divctl_o, 32'h0);
        chk("R1 run", {31'd0, run_o}, 32'h0);

        // Table walk: write, then read back
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) do_write(VEC[i].wsz, VEC[i].wa, VEC[i].wd);
            do_read(VEC[i].rsz, VEC[i].ra, v);
            chk($sformatf("R%0d vec%0d", VEC[i].req, i), v, VEC[i].exp);
        end

        // R12: divide control holds the written value; byte merge into lane 3
        chk("R12 divctl", divctl_o, 32'h0000_0055);
        do_write(2'd0, 5'h1F, 32'h0000_00AA);
        chk("R12 divctl byte", divctl_o, 32'h0000_00AA);

        // R6: live flags z=1 n=1 c=0 read back in bits 2:0
        flag_z_i = 1'b1; flag_n_i = 1'b1;
        do_read(2'd2, 5'h00, v); chk("R6 live", v & 32'h7, 32'h5);
        do_read(2'd0, 5'h02, v); chk("R6 hidden byte", v & 32'h3E, 32'h0);
        flag_z_i = 1'b0; flag_n_i = 1'b0;

        // R11: run flag follows control bit 0
        do_write(2'd2, 5'h14, 32'h0000_0000);
        chk("R11 run off", {31'd0, run_o}, 32'h0);
        do_write(2'd2, 5'h14, 32'h0000_0001);
        chk("R11 run on", {31'd0, run_o}, 32'h1);

        // R9: host pulse for one cycle, bit not stored
        do_write(2'd2, 5'h14, 32'h0000_0003);
        chk("R9 pulse high", {31'd0, host_irq_o}, 32'h1);
        chk("R10 no line0", {31'd0, line0_o}, 32'h0);
        @(negedge clk); #1;
        chk("R9 pulse low", {31'd0, host_irq_o}, 32'h0);
        do_read(2'd2, 5'h14, v); chk("R9 unstored", v, 32'h0000_2001);

        // R9: byte write to lowest control lane also commands
        do_write(2'd0, 5'h17, 32'h0000_0002);
        chk("R9 byte pulse", {31'd0, host_irq_o}, 32'h1);

        // R10: line 0 pulse, bit not stored
        do_write(2'd2, 5'h14, 32'h0000_0004);
        chk("R10 pulse high", {31'd0, line0_o}, 32'h1);
        chk("R9 no host", {31'd0, host_irq_o}, 32'h0);
        @(negedge clk); #1;
        chk("R10 pulse low", {31'd0, line0_o}, 32'h0);
        do_read(2'd2, 5'h14, v); chk("R10 unstored", v, 32'h0000_2000);

        // R5: odd halfword write to PC has no effect
        do_write(2'd1, 5'h13, 32'h0000_1111);
        do_read(2'd2, 5'h10, v); chk("R5 pc kept", v, 32'h00F0_3ABC);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule